// File: doc/BRIEF.md
# Comma-aligning ten-bit deserializer

This block sits behind a clock-recovery front end. That front end delivers one recovered serial bit per cycle of a fast bit clock. The block collects the bits into 10-bit words that were 8B/10B encoded at the far end. It finds the word boundary by watching the stream for the comma pattern. When alignment is enabled, a comma seen at a new bit offset moves the boundary so that the comma character becomes the next word delivered. A control input freezes the boundary. While it is frozen, commas are still flagged when they arrive aligned, but they no longer shift the boundary.

Words leave on two byte strobes. Each strobe toggles at half the word rate, and the two are in opposite phase, so consecutive words line up with rising edges of the two strobes in turn. A small companion serializer captures a parallel word on a load pulse and shifts it out with the least significant bit first. A loop-back input routes that serializer's output into the receiver in place of the line bit.

Top module: `comma_deser10`

## Requirements
- R1: A synchronous active-high reset clears `rx_word` to 0, `rx_comma` to 0 and both strobes to 0. No word is delivered and no strobe rises until ten bits have been received after reset.
- R2: Received bits fill a word in arrival order, with the first received bit in bit 0. While alignment is disabled, the first ten bits after reset form the first word, and every following ten bits form the next word. Each word is delivered on the clock edge after its tenth bit is sampled.
- R3: While alignment is enabled (`sync_dis` = 0), a word is a comma when its bits 1:0 are equal and its bits 6:2 all hold the opposite value (00 then 11111, or 11 then 00000). When the last ten received bits form a comma whose boundary differs from the current one, the partial word is dropped. The comma is delivered on the next edge, and later words follow every ten bits from that boundary.
- R4: While `sync_dis` = 1, a comma at any other offset does not move the boundary. Words stay ten bits apart, and no delivered word is flagged unless its own bits form a comma.
- R5: `rx_comma` is 1 for exactly those delivered words whose bits match the comma rule of R3, and it changes together with `rx_word`.
- R6: The first word after reset raises `strobe_a` while `strobe_b` stays low. Each later word swaps the two strobe levels, so each new word arrives on a rising edge of the other strobe. `rx_word` and both strobes hold their values between deliveries.
- R7: When `loop_en` = 1, the receiver takes its bit from `tx_bit` as it stood before the edge, and `line_bit` has no effect.
- R8: On an edge where `tx_load` = 1 the serializer captures `tx_word`. Bit k of that word appears on `tx_bit` k+1 edges after the capture, and zeros follow once all ten bits have been sent.
- R9: A comma that arrives on the current boundary is delivered as a normal word and does not disturb the ten-bit spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, one bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| line_bit | input | 1 | Recovered serial bit from the line |
| loop_en | input | 1 | 1 selects the local serializer output as receive input |
| sync_dis | input | 1 | 1 freezes the word boundary |
| tx_word | input | 10 | Parallel word for the companion serializer |
| tx_load | input | 1 | Capture pulse for `tx_word` (byte clock edge) |
| tx_bit | output | 1 | Serializer output, LSB first |
| rx_word | output | 10 | Delivered parallel word |
| rx_comma | output | 1 | Delivered word is a comma character |
| strobe_a | output | 1 | Half-rate byte strobe, first phase |
| strobe_b | output | 1 | Half-rate byte strobe, opposite phase |

## Verification
The hardest case to reach is a comma landing at an offset away from the running boundary. From the ports, this only happens when a few stray bits are inserted into an otherwise continuous bit stream. The stimulus therefore sends three or four loose bits ahead of a comma twice: once with alignment frozen, where the spacing must hold, and once with it enabled, where the partial word must be dropped. Loop-back is entered with the serializer at an unrelated phase and the line held at all ones, so the receiver can only produce the expected words by realigning on a comma sent through the serializer.

// File: rtl/deser10_pkg.sv
package deser10_pkg;

  localparam int WORD_W  = 10;
  localparam int COMMA_W = 7;

  // comma bits in arrival order, bit 0 arrived first: 0,0,1,1,1,1,1
  localparam logic [COMMA_W-1:0] COMMA_BITS = 7'b1111100;

  // true for either running-disparity form of the comma
  function automatic logic comma_match(input logic [COMMA_W-1:0] f);
    return (f == COMMA_BITS) || (f == ~COMMA_BITS);
  endfunction

endpackage

// File: rtl/deser10_txser.sv
module deser10_txser #(
  parameter int WORD_W = deser10_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              load_i,
  output logic              bit_o
);

  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else if (load_i) shreg <= word_i;
    else shreg <= {1'b0, shreg[WORD_W-1:1]};
  end

  assign bit_o = shreg[0];

  AST_TX_FIRST: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (bit_o == $past(word_i[0]))); // R8

  AST_TX_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !$past(rst)) |=> (bit_o == $past(shreg[1]))); // R8

endmodule

// File: rtl/deser10_aligner.sv
module deser10_aligner #(
  parameter int WORD_W  = deser10_pkg::WORD_W,
  parameter int COMMA_W = deser10_pkg::COMMA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_i,
  input  logic              sync_dis,
  output logic [WORD_W-1:0] win_o,
  output logic              take_o
);

  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] FULL = CW'(WORD_W);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [WORD_W-1:0] win;
  logic [CW-1:0]     cnt;      // bits since the last boundary
  logic [CW-1:0]     cnt_next;
  logic              primed;   // window has been filled once
  logic              hit;      // comma visible in the window
  logic              realign;  // comma allowed to move the boundary
  logic              take;

  assign hit      = primed && deser10_pkg::comma_match(win[COMMA_W-1:0]);
  assign realign  = hit && !sync_dis;
  assign take     = (cnt == FULL) || realign;
  assign cnt_next = take ? ONE : cnt + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      win    <= '0;
      cnt    <= '0;
      primed <= 1'b0;
    end else begin
      win <= {bit_i, win[WORD_W-1:1]};
      cnt <= cnt_next;
      if (cnt_next == FULL) primed <= 1'b1;
    end
  end

  assign win_o  = win;
  assign take_o = take;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL); // R2

  AST_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
    !primed |-> !take); // R1

  AST_REALIGN: assert property (@(posedge clk) disable iff (rst)
    realign |=> (cnt == ONE)); // R3

  AST_FROZEN_SPACING: assert property (@(posedge clk) disable iff (rst)
    (take && sync_dis) |-> (cnt == FULL)); // R4

endmodule

// File: rtl/deser10_strober.sv
module deser10_strober #(
  parameter int WORD_W  = deser10_pkg::WORD_W,
  parameter int COMMA_W = deser10_pkg::COMMA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic [WORD_W-1:0] win_i,
  output logic [WORD_W-1:0] word_o,
  output logic              comma_o,
  output logic              stb_a,
  output logic              stb_b
);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o  <= '0;
      comma_o <= 1'b0;
      stb_a   <= 1'b0;
      stb_b   <= 1'b0;
    end else if (take_i) begin
      word_o  <= win_i;
      comma_o <= deser10_pkg::comma_match(win_i[COMMA_W-1:0]);
      if (!stb_a && !stb_b) begin
        stb_a <= 1'b1;
      end else begin
        stb_a <= stb_b;
        stb_b <= stb_a;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!stb_a && !stb_b && word_o == '0 && !comma_o)); // R1

  AST_FIRST_A: assert property (@(posedge clk) disable iff (rst)
    (take_i && !stb_a && !stb_b) |=> (stb_a && !stb_b)); // R6

  AST_STROBE_SWAP: assert property (@(posedge clk) disable iff (rst)
    (take_i && (stb_a || stb_b)) |=> (stb_a == $past(stb_b) && stb_b == $past(stb_a))); // R6

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(stb_a && stb_b)); // R6

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> ($stable(word_o) && $stable(stb_a) && $stable(stb_b))); // R6

  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    comma_o |-> deser10_pkg::comma_match(word_o[COMMA_W-1:0])); // R5

endmodule

// File: rtl/comma_deser10.sv
module comma_deser10 #(
  parameter int WORD_W  = deser10_pkg::WORD_W,
  parameter int COMMA_W = deser10_pkg::COMMA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_bit,
  input  logic              loop_en,
  input  logic              sync_dis,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_load,
  output logic              tx_bit,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_comma,
  output logic              strobe_a,
  output logic              strobe_b
);

  logic              rx_in;   // selected receive bit
  logic [WORD_W-1:0] win;
  logic              take;    // word boundary event

  deser10_txser #(.WORD_W(WORD_W)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .word_i (tx_word),
    .load_i (tx_load),
    .bit_o  (tx_bit)
  );

  assign rx_in = loop_en ? tx_bit : line_bit;

  deser10_aligner #(.WORD_W(WORD_W), .COMMA_W(COMMA_W)) u_align (
    .clk      (clk),
    .rst      (rst),
    .bit_i    (rx_in),
    .sync_dis (sync_dis),
    .win_o    (win),
    .take_o   (take)
  );

  deser10_strober #(.WORD_W(WORD_W), .COMMA_W(COMMA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .take_i  (take),
    .win_i   (win),
    .word_o  (rx_word),
    .comma_o (rx_comma),
    .stb_a   (strobe_a),
    .stb_b   (strobe_b)
  );

  AST_LOOP_SRC: assert property (@(posedge clk) disable iff (rst)
    (loop_en && !$past(rst)) |=> (u_align.win_o[WORD_W-1] == $past(tx_bit))); // R7

endmodule

// File: tb/comma_deser10_test.sv
`timescale 1ns/1ps
module comma_deser10_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_bit = 1'b0;
  logic       loop_en = 1'b0;
  logic       sync_dis = 1'b1;
  logic [9:0] tx_word = '0;
  logic       tx_load = 1'b0;
  logic       tx_bit;
  logic [9:0] rx_word;
  logic       rx_comma;
  logic       strobe_a;
  logic       strobe_b;

  comma_deser10 uut (
    .clk(clk), .rst(rst), .line_bit(line_bit), .loop_en(loop_en),
    .sync_dis(sync_dis), .tx_word(tx_word), .tx_load(tx_load),
    .tx_bit(tx_bit), .rx_word(rx_word), .rx_comma(rx_comma),
    .strobe_a(strobe_a), .strobe_b(strobe_b)
  );

  always #4 clk = ~clk;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // comma rule: first two bits agree, next five all oppose them
  function automatic bit is_k(input logic [9:0] w);
    bit r = (w[0] == w[1]);
    for (int k = 2; k < 7; k++) if (w[k] == w[0]) r = 0;
    return r;
  endfunction

  // ---------------- reference model ----------------
  logic q[$];
  int   since;
  logic [9:0] m_tx, m_word;
  logic m_flag, m_sa, m_sb;
  bit   started = 0;

  function automatic logic [9:0] pack_q();
    logic [9:0] w = '0;
    for (int i = 0; i < q.size(); i++) w[i] = q[i];
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); since = 0; m_tx = '0; m_word = '0;
      m_flag = 0; m_sa = 0; m_sb = 0; started = 1;
    end else begin
      logic s, t, hit, bnd;
      logic [9:0] cur;
      s   = loop_en ? m_tx[0] : line_bit;
      cur = pack_q();
      hit = (q.size() == 10) && is_k(cur);
      bnd = (since == 10) || (hit && !sync_dis);
      if (bnd) begin
        m_word = cur;
        m_flag = is_k(cur);
        if (!m_sa && !m_sb) m_sa = 1;
        else begin t = m_sa; m_sa = m_sb; m_sb = t; end
      end
      q.push_back(s);
      if (q.size() > 10) void'(q.pop_front());
      since = bnd ? 1 : since + 1;
      m_tx = tx_load ? tx_word : (m_tx >> 1);
    end
  end

  // ---------------- per-cycle compare and delivery log ----------------
  logic [9:0] got[$];
  logic       gotf[$];
  logic pa = 0, pb = 0;
  int   rise_a = 0, rise_b = 0;

  always @(negedge clk) begin
    if (started && !done) begin
      chk({strobe_a, strobe_b, rx_comma, rx_word} === {m_sa, m_sb, m_flag, m_word},
          cur_req, {19'd0, strobe_a, strobe_b, rx_comma, rx_word},
          {19'd0, m_sa, m_sb, m_flag, m_word});
      chk(tx_bit === m_tx[0], "R8", {31'd0, tx_bit}, {31'd0, m_tx[0]});
      if ((strobe_a && !pa) || (strobe_b && !pb)) begin
        got.push_back(rx_word);
        gotf.push_back(rx_comma);
      end
      if (strobe_a && !pa) rise_a++;
      if (strobe_b && !pb) rise_b++;
      pa = strobe_a; pb = strobe_b;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send_range(input logic [9:0] w, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      line_bit = w[i];
      @(negedge clk);
    end
  endtask

  task automatic send_word(input logic [9:0] w);
    send_range(w, 0, 9);
  endtask

  task automatic tx_send(input logic [9:0] w);
    tx_word = w;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    repeat (9) @(negedge clk);
  endtask

  localparam logic [9:0] KN = 10'h17C; // 0,0,1,1,1,1,1,0,1,0
  localparam logic [9:0] KP = 10'h283; // 1,1,0,0,0,0,0,1,0,1
  localparam logic [9:0] FL = 10'h2AA;

  logic [9:0] wl [5];
  int mark, n, nflag;

  initial begin
    wl[0] = 10'h3A5; wl[1] = 10'h155; wl[2] = 10'h0C3; wl[3] = 10'h2D4; wl[4] = 10'h133;
    repeat (3) @(negedge clk);
    chk(rx_word == 0 && !rx_comma && !strobe_a && !strobe_b, "R1",
        {19'd0, strobe_a, strobe_b, rx_comma, rx_word}, 32'd0);
    rst = 1'b0;

    // R1: nothing before the tenth bit
    send_range(wl[0], 0, 8);
    chk(got.size() == 0 && !strobe_a && !strobe_b, "R1", got.size(), 0);
    send_range(wl[0], 9, 9);

    // R2: free-running boundary from reset, alignment frozen
    cur_req = "R2";
    for (int i = 1; i < 5; i++) send_word(wl[i]);
    send_word(FL);
    chk(got.size() == 5, "R2", got.size(), 5);
    for (int i = 0; i < 5; i++) chk(got[i] == wl[i], "R2", got[i], wl[i]);

    // R4: misaligned comma while frozen
    cur_req = "R4";
    mark = got.size();
    send_range(10'h005, 0, 2);
    send_word(KP);
    send_word(10'h155);
    send_word(FL);
    nflag = 0;
    for (int i = mark; i < got.size(); i++) if (gotf[i]) nflag++;
    chk(nflag == 0, "R4", nflag, 0);
    chk(got.size() - mark == 4, "R4", got.size() - mark, 4);

    // R3: alignment enabled, stray bits then comma
    cur_req = "R3";
    sync_dis = 1'b0;
    send_range(10'h005, 0, 3);
    send_word(KN);
    send_word(10'h155);
    send_word(10'h133);
    send_word(FL);
    n = got.size();
    chk(got[n-3] == KN, "R3", got[n-3], KN);
    chk(got[n-2] == 10'h155, "R3", got[n-2], 10'h155);
    chk(got[n-1] == 10'h133, "R3", got[n-1], 10'h133);
    chk(gotf[n-3] == 1'b1, "R5", gotf[n-3], 1);
    chk(gotf[n-1] == 1'b0 && gotf[n-2] == 1'b0, "R5", {gotf[n-2], gotf[n-1]}, 0);

    // R9: comma on the existing boundary
    cur_req = "R9";
    mark = got.size();
    send_word(KP);
    send_word(10'h2D4);
    send_word(FL);
    n = got.size();
    chk(got[n-2] == KP && gotf[n-2], "R9", {gotf[n-2], got[n-2]}, {1'b1, KP});
    chk(got[n-1] == 10'h2D4, "R9", got[n-1], 10'h2D4);
    chk(n - mark == 3, "R9", n - mark, 3);

    // R7: loop-back with the line stuck high
    cur_req = "R7";
    line_bit = 1'b1;
    loop_en = 1'b1;
    tx_send(10'h155);
    tx_send(KN);
    tx_send(10'h155);
    tx_send(10'h133);
    tx_send(FL);
    n = got.size();
    chk(got[n-3] == KN && gotf[n-3], "R7", {gotf[n-3], got[n-3]}, {1'b1, KN});
    chk(got[n-2] == 10'h155, "R7", got[n-2], 10'h155);
    chk(got[n-1] == 10'h133, "R7", got[n-1], 10'h133);
    repeat (12) @(negedge clk);

    // R6: strobes alternate, one rising edge per delivered word
    chk(rise_a + rise_b == got.size(), "R6", rise_a + rise_b, got.size());
    chk(rise_a - rise_b <= 1 && rise_a - rise_b >= 0, "R6", rise_a, rise_b);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule